// File: doc/BRIEF.md
# Twin Four-Bit Up-Counter with Swappable Count Inputs

The block holds two independent four-bit up-counters, called lanes. A static parameter picks the counting mode for both lanes. In decade mode a lane counts 0 to 9. In binary mode it counts 0 to 15. Each lane has three control inputs: a tick input, a gate input and a clear input. Each lane also has a four-bit count output.

A lane advances on either of two events:
- a rising tick while the gate is high;
- a falling gate while the tick is low.

Because of this, the two inputs can trade roles. This lets lanes be chained: feed the top count bit of one lane into the gate of the next lane, and hold that next lane's tick low. The tick and gate inputs may come from any timing domain. They pass through a two-flop synchronizer onto the fast system clock, and edges are found there. All four bits of a lane change on the same system-clock edge.

Top module: `twin_count4`

## Requirements
- R1: While `rst` is high, every lane count is 0 on the next clock edge.
- R2: A rising tick while the gate is high adds one to that lane. The new count appears on the third system-clock edge after the input change.
- R3: A falling gate while the tick is low adds one to that lane.
- R4: None of these changes alter the count: a rising tick with the gate low, a falling gate with the tick high, a falling tick, or a rising gate.
- R5: In decade mode (`MODE` = CNT_DECADE) the count goes from 9 to 0 and never exceeds 9.
- R6: In binary mode (`MODE` = CNT_BINARY) the count goes from 15 to 0.
- R7: A high clear input zeroes its own lane on the next edge and leaves the other lane unchanged.
- R8: While a lane's clear input is high, its tick and gate edges are ignored. Releasing the clear with steady inputs adds no count.
- R9: The lanes are independent: stimulus on one lane leaves the other lane's count unchanged.
- R10: When bit 3 of lane 0 drives lane 1's gate and lane 1's tick is held low, lane 1 adds one each time lane 0 wraps to 0.
- R11: A count changes by at most one step per system cycle. That step is either +1 or a wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | LANES | Per-lane tick input; bit i belongs to lane i |
| gate_in | input | LANES | Per-lane gate input, the second count source |
| clear_in | input | LANES | Per-lane clear, active high |
| count_out | output | LANES*CNT_W | Lane i count in bits [4i+3:4i] |

## Verification
The bench drives a decade instance and a binary instance with identical stimulus, so both wrap points are reached and compared in one run.

It targets the edge combinations that must not count. A design that treated both inputs as plain clocks would count a falling gate while the tick is high, and would also count a falling tick.

It targets edges that arrive while a clear is held. A design that only masked the clear's own cycle would count those edges once the clear drops.

The cascaded run checks that lane 1 advances once per lane 0 wrap. A design that counted the rising top bit would advance one wrap early, or twice per wrap.

// File: rtl/twin_count4_pkg.sv
package twin_count4_pkg;

    localparam int CNT_W       = 4;
    localparam int DECADE_LAST = 9;

    typedef logic [CNT_W-1:0] count_t;

    typedef enum logic {
        CNT_DECADE = 1'b0,
        CNT_BINARY = 1'b1
    } cnt_mode_e;

    // Synchronized level of the two count sources of one lane
    typedef struct packed {
        logic tick;
        logic gate;
    } pin_pair_t;

    // Next count value; any decade value past the last digit folds to zero
    function automatic count_t next_count(input count_t cur, input cnt_mode_e mode);
        if (mode == CNT_DECADE && cur >= count_t'(DECADE_LAST))
            return '0;
        return cur + count_t'(1);
    endfunction

endpackage

// File: rtl/twin_count4_sync.sv
module twin_count4_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= d_in;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/twin_count4_edge.sv
module twin_count4_edge
    import twin_count4_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_pair_t now_lvl,
    output logic      step_req
);
    pin_pair_t prev_lvl;

    // History follows the samples every cycle, so edges seen during a clear are consumed
    always_ff @(posedge clk) begin
        if (rst)
            prev_lvl <= '0;
        else
            prev_lvl <= now_lvl;
    end

    logic tick_rise, gate_fall;
    assign tick_rise = now_lvl.tick & ~prev_lvl.tick;
    assign gate_fall = prev_lvl.gate & ~now_lvl.gate;

    always_comb begin
        step_req = (tick_rise & now_lvl.gate) | (gate_fall & ~now_lvl.tick);
    end

    assert_quiet_after_rst_R1: assert property (@(posedge clk) rst |=> !step_req);
endmodule

// File: rtl/twin_count4_lane.sv
module twin_count4_lane
    import twin_count4_pkg::*;
#(
    parameter cnt_mode_e MODE = CNT_DECADE
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   step_req,
    output count_t cnt
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (step_req)
            cnt <= next_count(cnt, MODE);
    end

    assert_rst_zero_R1: assert property (@(posedge clk) rst |=> cnt == '0);

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt == '0);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!clear && !step_req) |=> $stable(cnt));

    assert_single_step_R11: assert property (@(posedge clk) disable iff (rst)
        (!clear && step_req) |=> (cnt == '0 || cnt == count_t'($past(cnt) + 1'b1)));

    assert_decade_range_R5: assert property (@(posedge clk) disable iff (rst)
        (MODE == CNT_DECADE) |-> cnt <= count_t'(DECADE_LAST));
endmodule

// File: rtl/twin_count4.sv
module twin_count4
    import twin_count4_pkg::*;
#(
    parameter int        LANES       = 2,
    parameter int        SYNC_STAGES = 2,
    parameter cnt_mode_e MODE        = CNT_DECADE
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       tick_in,
    input  logic [LANES-1:0]       gate_in,
    input  logic [LANES-1:0]       clear_in,
    output logic [LANES*CNT_W-1:0] count_out
);
    localparam int PAIR_W = $bits(pin_pair_t);

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            pin_pair_t raw_pair, sync_pair;
            logic      step_req;
            count_t    cnt;

            assign raw_pair.tick = tick_in[i];
            assign raw_pair.gate = gate_in[i];

            twin_count4_sync #(.STAGES(SYNC_STAGES), .W(PAIR_W)) u_sync (
                .clk   (clk),
                .rst   (rst),
                .d_in  (raw_pair),
                .q_out (sync_pair)
            );

            twin_count4_edge u_edge (
                .clk      (clk),
                .rst      (rst),
                .now_lvl  (sync_pair),
                .step_req (step_req)
            );

            twin_count4_lane #(.MODE(MODE)) u_lane (
                .clk      (clk),
                .rst      (rst),
                .clear    (clear_in[i]),
                .step_req (step_req),
                .cnt      (cnt)
            );

            assign count_out[i*CNT_W +: CNT_W] = cnt;
        end
    endgenerate
endmodule

// File: tb/twin_count4_bench.sv
module twin_count4_bench;
    import twin_count4_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] tick = '0;
    logic [1:0] gate = '0;
    logic [1:0] clr  = '0;
    logic       cascade = 1'b0;
    logic [7:0] qd, qb;
    logic [1:0] gate_d, gate_b;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;  // 250 MHz

    // Cascade mode: bit 3 of lane 0 feeds lane 1's gate
    always_comb begin
        gate_d = {cascade ? qd[3] : gate[1], gate[0]};
        gate_b = {cascade ? qb[3] : gate[1], gate[0]};
    end

    twin_count4 #(.MODE(CNT_DECADE)) u_twin_count4 (
        .clk(clk), .rst(rst), .tick_in(tick), .gate_in(gate_d),
        .clear_in(clr), .count_out(qd));

    twin_count4 #(.MODE(CNT_BINARY)) u_twin_count4_bin (
        .clk(clk), .rst(rst), .tick_in(tick), .gate_in(gate_b),
        .clear_in(clr), .count_out(qb));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input int d0, input int d1,
                             input int b0, input int b1);
        check({req, " dec lane0"}, int'(qd[3:0]), d0);
        check({req, " dec lane1"}, int'(qd[7:4]), d1);
        check({req, " bin lane0"}, int'(qb[3:0]), b0);
        check({req, " bin lane1"}, int'(qb[7:4]), b1);
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_pulse(input int lane);
        tick[lane] = 1'b1; settle();
        tick[lane] = 1'b0; settle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset", 0, 0, 0, 0);
        rst = 1'b0;
        settle();
        check_all("R1 after release", 0, 0, 0, 0);
    endtask

    task automatic t_clock_source();
        gate[0] = 1'b1; settle();
        check_all("R4 gate rise", 0, 0, 0, 0);
        // Exact latency: the count moves on the third edge after the input change
        tick[0] = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        check("R2 latency two edges", int'(qd[3:0]), 0);
        @(posedge clk); @(negedge clk);
        check("R2 latency three edges", int'(qd[3:0]), 1);
        tick[0] = 1'b0; settle();
        tick_pulse(0); tick_pulse(0);
        check_all("R2 tick count R9", 3, 0, 3, 0);
        gate[0] = 1'b0; settle();
        check_all("R3 gate fall", 4, 0, 4, 0);
    endtask

    task automatic t_gate_source();
        for (int k = 0; k < 2; k++) begin
            gate[0] = 1'b1; settle();
            gate[0] = 1'b0; settle();
        end
        check_all("R3 gate pulses", 6, 0, 6, 0);
    endtask

    task automatic t_ignored();
        tick[0] = 1'b1; settle();
        check_all("R4 tick rise gate low", 6, 0, 6, 0);
        gate[0] = 1'b1; settle();
        gate[0] = 1'b0; settle();
        check_all("R4 gate fall tick high", 6, 0, 6, 0);
        tick[0] = 1'b0; settle();
        check_all("R4 tick fall", 6, 0, 6, 0);
    endtask

    task automatic t_wrap();
        gate[0] = 1'b1; settle();
        for (int k = 0; k < 3; k++) tick_pulse(0);
        check_all("R5 at nine", 9, 0, 9, 0);
        tick_pulse(0);
        check_all("R5 decade wrap", 0, 0, 10, 0);
        for (int k = 0; k < 5; k++) tick_pulse(0);
        check_all("R6 at fifteen", 5, 0, 15, 0);
        tick_pulse(0);
        check_all("R6 binary wrap", 6, 0, 0, 0);
        gate[0] = 1'b0; settle();
        check_all("R3 gate fall after wrap", 7, 0, 1, 0);
    endtask

    task automatic t_lane1();
        gate[1] = 1'b1; settle();
        tick_pulse(1); tick_pulse(1);
        gate[1] = 1'b0; settle();
        check_all("R9 lane1 only", 7, 3, 1, 3);
    endtask

    task automatic t_clear();
        clr[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        check_all("R7 clear one edge", 0, 3, 0, 3);
        gate[0] = 1'b1; settle();
        tick_pulse(0); tick_pulse(0);
        gate[0] = 1'b0; settle();
        check_all("R8 edges during clear", 0, 3, 0, 3);
        clr[0] = 1'b0; settle();
        check_all("R8 after clear release", 0, 3, 0, 3);
    endtask

    task automatic t_cascade();
        rst = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        rst = 1'b0;
        cascade = 1'b1;
        gate[0] = 1'b1; settle();
        for (int k = 0; k < 35; k++) tick_pulse(0);
        check_all("R10 cascade", 35 % 10, 35 / 10, 35 % 16, 35 / 16);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_clock_source();
        t_gate_source();
        t_ignored();
        t_wrap();
        t_lane1();
        t_clear();
        t_cascade();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule